// File: doc/BRIEF.md
# Posted Write Buffer with I/O Ordering

This block sits between a processor core and a simple external bus. Core writes are placed in a small FIFO and acknowledged at once, so the core never waits for the bus on a store. Core reads are given the bus ahead of any buffered write. The result is low read latency, but a read can overtake a write that the program issued earlier.

For memory this reordering is harmless. For I/O devices it is not: a read of a data register that overtakes a write to a control register would observe the device in the wrong state. The unit therefore asserts an inhibit output on every read it places on the bus while writes are still buffered. An I/O target answers every access in its address range with a decode input. When decode is set on an inhibited read, the target has ignored the access, so the unit discards the result. It then pushes every buffered write out in order and issues the same read again, this time without inhibit. A read whose completing cycle carried decode is reported to the core as not cacheable.

Each bus cycle ends when the target raises ready. Decode is sampled on the same edge as ready. Only one read is outstanding at a time.

Top module: `pwb_unit`

## Requirements
- R1: After reset, bus_rd, bus_wr and bus_inhibit are low, cr_done is low, and both cw_ack and cr_ready are high.
- R2: While the buffer holds fewer than 4 writes, a core write is accepted on the edge where it is presented (cw_ack high), even if the bus is stalled.
- R3: With 4 writes buffered (a write stays buffered until its bus cycle receives ready), cw_ack is low and a further core write waits until one buffered write completes on the bus.
- R4: When a core read is waiting and writes are buffered, the read is the next bus cycle started after the cycle in progress ends.
- R5: A bus read carries bus_inhibit=1 exactly when the buffer holds at least one write at the time the read starts.
- R6: An inhibited read that completes with bus_decode=0 returns its bus data to the core, and the buffered writes follow it on the bus afterwards.
- R7: An inhibited read that completes with bus_decode=1 is discarded. All buffered writes then go to the bus in order, followed by the same read with bus_inhibit=0, and the core receives that reissued read's data.
- R8: cr_cacheable equals the inverse of bus_decode sampled on the completing cycle of the read, whatever the address.
- R9: Buffered writes appear on the bus in the order the core posted them, each with its own address and data.
- R10: At most one of bus_rd and bus_wr is high at any time, and a strobe with its address stays unchanged until ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cw_valid | input | 1 | Core write request |
| cw_ack | output | 1 | Write accepted this edge when cw_valid is high |
| cw_addr | input | 16 | Core write address |
| cw_data | input | 16 | Core write data |
| cr_valid | input | 1 | Core read request |
| cr_ready | output | 1 | No read outstanding; a read request is taken |
| cr_addr | input | 16 | Core read address |
| cr_done | output | 1 | One-cycle pulse: read result valid |
| cr_rdata | output | 16 | Read result |
| cr_cacheable | output | 1 | Result may be cached (no decode seen) |
| bus_addr | output | 16 | Bus address |
| bus_wdata | output | 16 | Bus write data |
| bus_rdata | input | 16 | Bus read data |
| bus_rd | output | 1 | Read strobe |
| bus_wr | output | 1 | Write strobe |
| bus_inhibit | output | 1 | Target must ignore this read |
| bus_ready | input | 1 | Target ends the current cycle |
| bus_decode | input | 1 | Target is an I/O device |

## Verification
Two of the block's functions can fall on the same edge: posting a write and taking a read. This happens when the core presents a control-register write and a data-register read together. The bench provokes it by raising cw_valid and cr_valid in the same cycle. It then judges the result by the logged bus order (inhibited read, write, clean read) and by whether the returned data reflects the value just written. A sweep over 0 to 4 buffered writes, crossed with memory and I/O targets, checks the same contention with the bus held busy. In each case the exact expected cycle sequence is computed arithmetically.

// File: rtl/pwb_pkg.sv
package pwb_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RD   = 2'd1,
    ST_WR   = 2'd2
  } bus_st_e;

  // circular pointer advance
  function automatic int unsigned wrap_inc(int unsigned p, int unsigned lim);
    return (p + 1 >= lim) ? 0 : p + 1;
  endfunction

  // a read must be abandoned when the target ignored it
  function automatic logic must_retry(logic inhibited, logic decoded);
    return inhibited & decoded;
  endfunction

  // the result may go to a cache only if no I/O target claimed it
  function automatic logic may_cache(logic decoded);
    return ~decoded;
  endfunction

endpackage

// File: rtl/pwb_wfifo.sv
module pwb_wfifo #(
  parameter int AW    = 16,
  parameter int DW    = 16,
  parameter int DEPTH = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic          pop,
  input  logic [AW-1:0] in_addr,
  input  logic [DW-1:0] in_data,
  output logic [AW-1:0] head_addr,
  output logic [DW-1:0] head_data,
  output logic          empty,
  output logic          full
);
  localparam int PTRW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW   = $clog2(DEPTH + 1);

  logic [PTRW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0]   cnt;
  logic [AW-1:0]   addr_v [DEPTH];
  logic [DW-1:0]   data_v [DEPTH];

  generate
    for (genvar g = 0; g < DEPTH; g++) begin : g_ent
      logic [AW-1:0] a_q;
      logic [DW-1:0] d_q;
      always_ff @(posedge clk) begin
        if (push && wr_ptr == PTRW'(g)) begin
          a_q <= in_addr;
          d_q <= in_data;
        end
      end
      assign addr_v[g] = a_q;
      assign data_v[g] = d_q;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt    <= '0;
    end else begin
      if (push) wr_ptr <= PTRW'(pwb_pkg::wrap_inc(32'(wr_ptr), DEPTH));
      if (pop)  rd_ptr <= PTRW'(pwb_pkg::wrap_inc(32'(rd_ptr), DEPTH));
      cnt <= cnt + CW'(push) - CW'(pop);
    end
  end

  assign head_addr = addr_v[rd_ptr];
  assign head_data = data_v[rd_ptr];
  assign empty     = (cnt == '0);
  assign full      = (cnt == CW'(DEPTH));

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> (cnt < CW'(DEPTH))); // R3
  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> (cnt != '0)); // R9

endmodule

// File: rtl/pwb_bus_seq.sv
module pwb_bus_seq #(
  parameter int AW = 16,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rd_pend,
  input  logic [AW-1:0] rd_addr,
  input  logic          fifo_empty,
  input  logic [AW-1:0] head_addr,
  input  logic [DW-1:0] head_data,
  output logic          pop,
  output logic          rd_complete,
  output logic          flush_q,
  output logic [AW-1:0] bus_addr,
  output logic [DW-1:0] bus_wdata,
  input  logic [DW-1:0] bus_rdata,
  output logic          bus_rd,
  output logic          bus_wr,
  output logic          bus_inhibit,
  input  logic          bus_ready,
  input  logic          bus_decode,
  output logic          cr_done,
  output logic [DW-1:0] cr_rdata,
  output logic          cr_cacheable
);
  import pwb_pkg::*;

  bus_st_e st;

  // named internal events
  logic rd_issue, wr_issue, retry;

  assign rd_issue    = (st == ST_IDLE) && rd_pend && (!flush_q || fifo_empty);
  assign wr_issue    = (st == ST_IDLE) && !fifo_empty && (!rd_pend || flush_q);
  assign retry       = (st == ST_RD) && bus_ready && must_retry(bus_inhibit, bus_decode);
  assign rd_complete = (st == ST_RD) && bus_ready && !retry;
  assign pop         = (st == ST_WR) && bus_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st           <= ST_IDLE;
      bus_rd       <= 1'b0;
      bus_wr       <= 1'b0;
      bus_inhibit  <= 1'b0;
      bus_addr     <= '0;
      bus_wdata    <= '0;
      flush_q      <= 1'b0;
      cr_done      <= 1'b0;
      cr_rdata     <= '0;
      cr_cacheable <= 1'b0;
    end else begin
      cr_done <= 1'b0;
      unique case (st)
        ST_IDLE: begin
          if (rd_issue) begin
            st          <= ST_RD;
            bus_rd      <= 1'b1;
            bus_addr    <= rd_addr;
            bus_inhibit <= !fifo_empty;
            flush_q     <= 1'b0;
          end else if (wr_issue) begin
            st        <= ST_WR;
            bus_wr    <= 1'b1;
            bus_addr  <= head_addr;
            bus_wdata <= head_data;
          end
        end
        ST_RD: begin
          if (bus_ready) begin
            st          <= ST_IDLE;
            bus_rd      <= 1'b0;
            bus_inhibit <= 1'b0;
            if (retry) begin
              flush_q <= 1'b1;
            end else begin
              cr_done      <= 1'b1;
              cr_rdata     <= bus_rdata;
              cr_cacheable <= may_cache(bus_decode);
            end
          end
        end
        ST_WR: begin
          if (bus_ready) begin
            st     <= ST_IDLE;
            bus_wr <= 1'b0;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_rd && bus_wr)); // R10
  AST_STROBE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && !bus_ready) |=> (bus_rd && $stable(bus_addr))); // R10
  AST_INH_NEEDS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(bus_rd) && bus_inhibit) |-> !fifo_empty); // R5
  AST_REISSUE_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(bus_rd) && $past(flush_q)) |-> !bus_inhibit); // R7
  AST_RD_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_wr) |-> (!$past(rd_pend) || $past(flush_q))); // R4
  AST_CACHE_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    cr_done |-> (cr_cacheable == !$past(bus_decode))); // R8

endmodule

// File: rtl/pwb_unit.sv
module pwb_unit #(
  parameter int AW    = 16,
  parameter int DW    = 16,
  parameter int DEPTH = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cw_valid,
  output logic          cw_ack,
  input  logic [AW-1:0] cw_addr,
  input  logic [DW-1:0] cw_data,
  input  logic          cr_valid,
  output logic          cr_ready,
  input  logic [AW-1:0] cr_addr,
  output logic          cr_done,
  output logic [DW-1:0] cr_rdata,
  output logic          cr_cacheable,
  output logic [AW-1:0] bus_addr,
  output logic [DW-1:0] bus_wdata,
  input  logic [DW-1:0] bus_rdata,
  output logic          bus_rd,
  output logic          bus_wr,
  output logic          bus_inhibit,
  input  logic          bus_ready,
  input  logic          bus_decode
);
  logic          push, pop, f_empty, f_full, flush_q, rd_complete;
  logic          rd_pend;
  logic [AW-1:0] rd_addr_q, head_addr;
  logic [DW-1:0] head_data;

  // writes are refused while a flush is in progress so the reissue finds the buffer empty
  assign cw_ack   = !f_full && !flush_q;
  assign push     = cw_valid && cw_ack;
  assign cr_ready = !rd_pend;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_pend   <= 1'b0;
      rd_addr_q <= '0;
    end else if (cr_valid && cr_ready) begin
      rd_pend   <= 1'b1;
      rd_addr_q <= cr_addr;
    end else if (rd_complete) begin
      rd_pend <= 1'b0;
    end
  end

  pwb_wfifo #(.AW(AW), .DW(DW), .DEPTH(DEPTH)) wfifo_i (
    .clk(clk), .rst_n(rst_n), .push(push), .pop(pop),
    .in_addr(cw_addr), .in_data(cw_data),
    .head_addr(head_addr), .head_data(head_data),
    .empty(f_empty), .full(f_full)
  );

  pwb_bus_seq #(.AW(AW), .DW(DW)) seq_i (
    .clk(clk), .rst_n(rst_n),
    .rd_pend(rd_pend), .rd_addr(rd_addr_q),
    .fifo_empty(f_empty), .head_addr(head_addr), .head_data(head_data),
    .pop(pop), .rd_complete(rd_complete), .flush_q(flush_q),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_inhibit(bus_inhibit),
    .bus_ready(bus_ready), .bus_decode(bus_decode),
    .cr_done(cr_done), .cr_rdata(cr_rdata), .cr_cacheable(cr_cacheable)
  );

  AST_DONE_HAS_READ: assert property (@(posedge clk) disable iff (!rst_n)
    cr_done |-> $past(rd_pend)); // R6
  AST_FLUSH_HOLDS_READ: assert property (@(posedge clk) disable iff (!rst_n)
    flush_q |-> rd_pend); // R7

endmodule

// File: tb/pwb_unit_tb_top.sv
module pwb_unit_tb_top;
  localparam int CLK_NS = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cw_valid = 1'b0, cr_valid = 1'b0;
  logic [15:0] cw_addr = '0, cw_data = '0, cr_addr = '0;
  logic        cw_ack, cr_ready, cr_done, cr_cacheable;
  logic [15:0] cr_rdata, bus_addr, bus_wdata;
  logic [15:0] bus_rdata = '0;
  logic        bus_rd, bus_wr, bus_inhibit;
  logic        bus_ready = 1'b0, bus_decode = 1'b0;

  always #(CLK_NS/2) clk = ~clk;

  pwb_unit dut_i (
    .clk(clk), .rst_n(rst_n),
    .cw_valid(cw_valid), .cw_ack(cw_ack), .cw_addr(cw_addr), .cw_data(cw_data),
    .cr_valid(cr_valid), .cr_ready(cr_ready), .cr_addr(cr_addr),
    .cr_done(cr_done), .cr_rdata(cr_rdata), .cr_cacheable(cr_cacheable),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_inhibit(bus_inhibit),
    .bus_ready(bus_ready), .bus_decode(bus_decode)
  );

  int nchk = 0, nfail = 0, cyc = 0, overlap = 0;

  task automatic chk(input string req, input string what, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // ---------------- target model: I/O space is 0xF000..0xFFFF ----------------
  function automatic logic [15:0] memval(logic [15:0] a);
    return a * 16'd3 + 16'd1;
  endfunction

  logic        hold = 1'b0;
  int          lat = 1, tcnt = 0;
  logic [15:0] tgt_ctrl = 16'h0000;
  int          lg_n = 0;
  int          lg_rd [16];
  int          lg_addr [16];
  int          lg_inh [16];
  int          lg_data [16];

  always @(negedge clk) begin
    if (bus_rd && bus_wr) overlap++;
    if (!rst_n) begin
      bus_ready = 1'b0; bus_decode = 1'b0; tcnt = 0;
    end else if (bus_ready) begin
      bus_ready = 1'b0; bus_decode = 1'b0;
    end else if ((bus_rd || bus_wr) && !hold) begin
      if (tcnt < lat) tcnt++;
      else begin
        logic io;
        tcnt = 0;
        io = (bus_addr[15:12] == 4'hF);
        bus_ready = 1'b1;
        bus_decode = io;
        if (bus_rd)
          bus_rdata = (io && bus_inhibit) ? 16'hDEAD :
                      io ? (tgt_ctrl ^ 16'h5A5A) : memval(bus_addr);
        else if (io && !bus_inhibit && bus_addr == 16'hF000)
          tgt_ctrl = bus_wdata;
        if (lg_n < 16) begin
          lg_rd[lg_n]   = int'(bus_rd);
          lg_addr[lg_n] = int'(bus_addr);
          lg_inh[lg_n]  = int'(bus_inhibit);
          lg_data[lg_n] = int'(bus_wdata);
        end
        lg_n++;
      end
    end
  end

  // ---------------- core-side tasks (called at a negedge) ----------------
  task automatic post_wr(input logic [15:0] a, input logic [15:0] d, output int waits);
    waits = 0;
    cw_valid = 1'b1; cw_addr = a; cw_data = d;
    while (!cw_ack && waits < 200) begin @(negedge clk); waits++; end
    @(negedge clk);
    cw_valid = 1'b0;
  endtask

  task automatic start_rd(input logic [15:0] a);
    cr_valid = 1'b1; cr_addr = a;
    while (!cr_ready) @(negedge clk);
    @(negedge clk);
    cr_valid = 1'b0;
  endtask

  task automatic wait_done(input string req, output logic [15:0] d, output logic c);
    int t;
    t = 0;
    while (!cr_done && t < 500) begin @(negedge clk); t++; end
    chk(req, "read completes", int'(t < 500), 1);
    d = cr_rdata; c = cr_cacheable;
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // watchdog
  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      nfail++;
      $display("FAIL watchdog expired after %0d cycles", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end

  int          ex_n;
  int          ex_rd [16];
  int          ex_addr [16];
  int          ex_inh [16];
  int          ex_data [16];

  task automatic ex_add(input int rd, input int a, input int inh, input int d);
    ex_rd[ex_n] = rd; ex_addr[ex_n] = a; ex_inh[ex_n] = inh; ex_data[ex_n] = d;
    ex_n++;
  endtask

  task automatic cmp_log(input string req);
    chk(req, "bus cycle count", lg_n, ex_n);
    for (int j = 0; j < ex_n && j < lg_n && j < 16; j++) begin
      chk(req, "cycle kind", lg_rd[j], ex_rd[j]);
      chk(req, "cycle addr", lg_addr[j], ex_addr[j]);
      chk(req, "cycle inhibit", lg_inh[j], ex_inh[j]);
      if (ex_rd[j] == 0) chk(req, "cycle wdata", lg_data[j], ex_data[j]);
    end
  endtask

  initial begin
    int w;
    logic [15:0] d;
    logic c;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1", "bus_rd", int'(bus_rd), 0);
    chk("R1", "bus_wr", int'(bus_wr), 0);
    chk("R1", "bus_inhibit", int'(bus_inhibit), 0);
    chk("R1", "cr_done", int'(cr_done), 0);
    chk("R1", "cw_ack", int'(cw_ack), 1);
    chk("R1", "cr_ready", int'(cr_ready), 1);

    // R2 / R3 / R9: fill buffer with bus stalled, then overflow attempt
    hold = 1'b1; lg_n = 0;
    for (int k = 0; k < 4; k++) begin
      post_wr(16'h3000 + 16'(k), 16'hC000 + 16'(k * 5), w);
      chk("R2", "write accepted without wait", w, 0);
    end
    cw_valid = 1'b1; cw_addr = 16'h3004; cw_data = 16'hC014;
    idle(4);
    chk("R3", "cw_ack low while full", int'(cw_ack), 0);
    hold = 1'b0;
    w = 0;
    while (!cw_ack && w < 100) begin @(negedge clk); w++; end
    chk("R3", "stall ends after a drain", int'(w < 100), 1);
    @(negedge clk);
    cw_valid = 1'b0;
    idle(40);
    ex_n = 0;
    for (int k = 0; k < 5; k++) ex_add(0, 16'h3000 + k, 0, 16'hC000 + k * 5);
    cmp_log("R9");

    // R7 ordering: control write and data read presented in the same cycle
    lat = 1;
    for (int v = 0; v < 4; v++) begin
      logic [15:0] cv;
      cv = 16'h1234 + 16'(v * 16'h1111);
      lg_n = 0;
      cw_valid = 1'b1; cw_addr = 16'hF000; cw_data = cv;
      cr_valid = 1'b1; cr_addr = 16'hF004;
      @(negedge clk);
      cw_valid = 1'b0; cr_valid = 1'b0;
      wait_done("R7", d, c);
      idle(10);
      chk("R7", "data reflects the earlier write", int'(d), int'(cv ^ 16'h5A5A));
      chk("R8", "io read not cacheable", int'(c), 0);
      ex_n = 0;
      ex_add(1, 16'hF004, 1, 0);
      ex_add(0, 16'hF000, 0, cv);
      ex_add(1, 16'hF004, 0, 0);
      cmp_log("R7");
    end

    // sweep: n buffered writes x memory / I/O read (R4 R5 R6 R7 R8)
    for (int n = 0; n <= 4; n++) begin
      for (int io = 0; io < 2; io++) begin
        logic [15:0] ra;
        ra = io ? 16'hF004 : 16'h2000 + 16'(n);
        lat = 1 + n % 2;
        hold = 1'b1; lg_n = 0;
        for (int k = 0; k < n; k++)
          post_wr(16'h1000 + 16'(k), 16'hA000 + 16'(k * 7 + n * 3), w);
        start_rd(ra);
        idle(3);
        hold = 1'b0;
        wait_done("R6", d, c);
        idle(40);
        chk(io ? "R7" : "R6", "sweep read data", int'(d),
            io ? int'(tgt_ctrl ^ 16'h5A5A) : int'(memval(ra)));
        chk("R8", "sweep cacheable", int'(c), io ? 0 : 1);
        ex_n = 0;
        if (n == 0) ex_add(1, ra, 0, 0);
        else begin
          ex_add(0, 16'h1000, 0, 16'hA000 + n * 3);
          ex_add(1, ra, (n > 1) ? 1 : 0, 0);       // R4 read next, R5 inhibit
          for (int k = 1; k < n; k++) ex_add(0, 16'h1000 + k, 0, 16'hA000 + k * 7 + n * 3);
          if (io && n > 1) ex_add(1, ra, 0, 0);
        end
        cmp_log(n > 1 ? "R5" : "R4");
      end
    end

    chk("R10", "strobes never overlap", overlap, 0);

    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

endmodule